// File: doc/BRIEF.md
# Per-Select Timed External Memory Bus Controller

This block connects a single-request internal port to a slow asynchronous parallel bus shared by up to six external devices. Each request names a chip select, a word address, a direction and (for writes) a 16-bit data word. The controller asserts the matching active-low chip select and sequences the output-enable, write-enable and address-valid strobes. Each strobe lasts as long as that chip select's timing word asks. Reads come back on a one-cycle response pulse.

Each chip select owns a 40-bit timing word, loaded through a simple write port. The word holds wait, hold and recovery counts and a first-access latency for each direction. It also holds an alternate mode in which an address-valid pulse leads the access, followed by an optional address-hold cycle and programmable gaps before output enable. A turnaround tracker remembers the previous access. A recovery gap with the bus released is placed in front of a new access only when a read is followed by an access to another chip select, or by a write on the same one.

Top module: `xbus_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, every chip select, output enable, write enable and address valid is high, the data bus is not driven, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A pulse on `cfg_wr` with `cfg_cs` in 0..5 stores `cfg_word` as that chip select's timing word. The fields by bit are: [3:0] read wait, [7:4] write wait, [11:8] write hold, [15:12] recovery, [23:16] read latency, [31:24] write latency, [35:32] read hold, [37:36] address-valid-to-output-enable gap, [38] address hold, [39] alternate mode. A `cfg_cs` of 6 or 7 changes nothing. All words are zero after reset.
- R3: During an access exactly the requested chip select is low: from the first setup cycle through the last strobe or hold cycle. At all other times no chip select is low, and never is more than one low.
- R4: The strobe (output enable for reads, write enable for writes) stays low for wait+1 cycles, using the read or write wait field. On a first access it also stays low for the read or write latency field.
- R5: An access counts as first when it is the first valid access since reset, or when its chip select differs from that of the previous valid access.
- R6: After a write strobe, the chip select stays low with write enable high for write-hold+1 cycles.
- R7: Recovery is placed before an access only when the previous valid access was a read, and the new access targets another chip select or is a write. It lasts max(recovery field, 1) cycles, with all chip selects high and the bus released. No recovery is placed otherwise.
- R8: Read data is sampled on the last output-enable-low cycle and returned on `rsp_rdata` with a one-cycle `rsp_valid` pulse on the following cycle. Writes produce no `rsp_valid`.
- R9: In alternate mode, address valid is low for exactly one cycle: the first cycle with the chip select low. The setup before the strobe lasts 1 + address-hold cycles for writes, and 1 + address-hold + gap + read-hold cycles for reads. In normal mode there is no setup and address valid stays high.
- R10: `ext_doe` is 1 only during write strobe and write hold cycles, and then `ext_dout` equals the request's write data. Output enable and write enable are never low together.
- R11: `req_ready` goes low on the cycle after acceptance and returns high after the last recovery, setup, strobe or hold cycle. The access takes exactly the sum of those phase lengths.
- R12: A request with chip select 6 or 7 is accepted and completes in one cycle with no strobe or chip select. A read returns 0 with `rsp_valid`. Such a request neither counts as the previous access for R5 or R7, nor disturbs the record of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Timing word write strobe |
| cfg_cs | input | 3 | Chip select whose timing word is written |
| cfg_word | input | 40 | Timing word value (fields in R2) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted when valid |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_cs | input | 3 | Target chip select |
| req_addr | input | 9 | Word address driven on the external bus |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 16 | Read data |
| ext_addr | output | 9 | External address lines |
| ext_dout | output | 16 | External data out |
| ext_doe | output | 1 | External data output drive enable |
| ext_din | input | 16 | External data in |
| ext_cs_n | output | 6 | Active-low chip selects |
| ext_oe_n | output | 1 | Active-low output enable |
| ext_we_n | output | 1 | Active-low write enable |
| ext_adv_n | output | 1 | Active-low address valid |

## Verification
The bench targets the turnaround cases. It runs read then write on one select, read then read on one select, read then another select, write then read, and access after an out-of-range request. A design that misjudges them shows a recovery gap where none belongs, or bus contention where one was owed. Read data is driven correct only on the final output-enable cycle, so sampling one cycle early or late returns the inverted word. Zero-valued fields check that recovery rounds up to one while wait and hold add one. A maximum first-access latency and alternate-mode setups with every gap component present check the phase length arithmetic. A write to an invalid timing slot, followed by an access, checks that no real slot was overwritten.

// File: rtl/xbc_pkg.sv
package xbc_pkg;

  localparam int CFG_W = 40;
  localparam int CNT_W = 9;

  // Per chip-select timing word (bit positions listed in the brief)
  typedef struct packed {
    logic       alt;     // address-valid led timing
    logic       ahold;   // one extra address cycle after address valid
    logic [1:0] a2o;     // address valid to output enable gap
    logic [3:0] rhold;   // read hold before output enable
    logic [7:0] wdelta;  // first-access write latency
    logic [7:0] rdelta;  // first-access read latency
    logic [3:0] recov;   // turnaround recovery
    logic [3:0] whold;   // write hold
    logic [3:0] wwait;   // write strobe wait
    logic [3:0] rwait;   // read strobe wait
  } tcfg_t;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_REC  = 3'd1,
    PH_PRE  = 3'd2,
    PH_STRB = 3'd3,
    PH_HOLD = 3'd4,
    PH_NULL = 3'd5
  } phase_t;

  function automatic logic [CNT_W-1:0] strobe_len(tcfg_t t, logic wr, logic first);
    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] extra;
    base  = wr ? CNT_W'(t.wwait) : CNT_W'(t.rwait);
    extra = '0;
    if (first) extra = wr ? CNT_W'(t.wdelta) : CNT_W'(t.rdelta);
    return base + extra + CNT_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] hold_len(tcfg_t t);
    return CNT_W'(t.whold) + CNT_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] rec_len(tcfg_t t);
    return (t.recov == 4'd0) ? CNT_W'(1) : CNT_W'(t.recov);
  endfunction

  function automatic logic [CNT_W-1:0] pre_len(tcfg_t t, logic wr);
    logic [CNT_W-1:0] n;
    n = '0;
    if (t.alt) begin
      n = CNT_W'(1) + CNT_W'(t.ahold);
      if (!wr) n = n + CNT_W'(t.a2o) + CNT_W'(t.rhold);
    end
    return n;
  endfunction

endpackage

// File: rtl/xbc_cfg_bank.sv
module xbc_cfg_bank
  import xbc_pkg::*;
#(
  parameter int NUM_CS = 6,
  parameter int CSW    = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [CSW-1:0] wr_sel,
  input  tcfg_t          wr_word,
  input  logic [CSW-1:0] rd_sel,
  output tcfg_t          rd_word
);

  tcfg_t             bank [NUM_CS];
  logic [NUM_CS-1:0] hit;

  genvar g;
  generate
    for (g = 0; g < NUM_CS; g++) begin : g_hit
      assign hit[g] = wr_en && (wr_sel == CSW'(g));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CS; i++) bank[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_CS; i++) begin
        if (hit[i]) bank[i] <= wr_word;
      end
    end
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (rd_sel == CSW'(i)) rd_word = bank[i];
    end
  end

endmodule

// File: rtl/xbc_turn.sv
module xbc_turn #(
  parameter int CSW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           log_en,
  input  logic [CSW-1:0] cs,
  input  logic           wr,
  output logic           need_rec,
  output logic           first
);

  logic           h_vld;
  logic           h_rd;
  logic [CSW-1:0] h_cs;

  assign first    = !h_vld || (h_cs != cs);
  assign need_rec = h_vld && h_rd && ((h_cs != cs) || wr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_vld <= 1'b0;
      h_rd  <= 1'b0;
      h_cs  <= '0;
    end else if (log_en) begin
      h_vld <= 1'b1;
      h_rd  <= !wr;
      h_cs  <= cs;
    end
  end

endmodule

// File: rtl/xbc_seq.sv
module xbc_seq
  import xbc_pkg::*;
#(
  parameter int NUM_CS = 6,
  parameter int CSW    = 3,
  parameter int AW     = 9,
  parameter int DW     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cs_ok,
  input  logic              wr,
  input  logic [CSW-1:0]    cs,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  input  tcfg_t             tcfg,
  input  logic              need_rec,
  input  logic              first,
  input  logic [DW-1:0]     ext_din,
  output logic              idle,
  output phase_t            phase,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  output logic [AW-1:0]     ext_addr,
  output logic [DW-1:0]     ext_dout,
  output logic              ext_doe,
  output logic [NUM_CS-1:0] ext_cs_n,
  output logic              ext_oe_n,
  output logic              ext_we_n,
  output logic              ext_adv_n
);

  phase_t           st, st_d;
  logic [CNT_W-1:0] cnt, cnt_d;
  logic             cnt_last;

  logic             c_wr, c_first;
  logic [CSW-1:0]   c_cs;
  tcfg_t            c_cfg;

  // Values of the access being started or in flight
  logic             src_wr, src_first;
  logic [CSW-1:0]   src_cs;
  tcfg_t            src_cfg;
  logic [CNT_W-1:0] pre_n, strb_n, hold_n, rec_n;

  assign src_wr    = (st == PH_IDLE) ? wr    : c_wr;
  assign src_first = (st == PH_IDLE) ? first : c_first;
  assign src_cs    = (st == PH_IDLE) ? cs    : c_cs;
  assign src_cfg   = (st == PH_IDLE) ? tcfg  : c_cfg;

  assign pre_n  = pre_len(src_cfg, src_wr);
  assign strb_n = strobe_len(src_cfg, src_wr, src_first);
  assign hold_n = hold_len(src_cfg);
  assign rec_n  = rec_len(src_cfg);

  assign cnt_last = (cnt == '0);
  assign idle     = (st == PH_IDLE);
  assign phase    = st;

  always_comb begin
    st_d  = st;
    cnt_d = cnt;
    unique case (st)
      PH_IDLE: begin
        if (start) begin
          if (!cs_ok) begin
            st_d  = PH_NULL;
            cnt_d = '0;
          end else if (need_rec) begin
            st_d  = PH_REC;
            cnt_d = rec_n - CNT_W'(1);
          end else if (pre_n != '0) begin
            st_d  = PH_PRE;
            cnt_d = pre_n - CNT_W'(1);
          end else begin
            st_d  = PH_STRB;
            cnt_d = strb_n - CNT_W'(1);
          end
        end
      end
      PH_REC: begin
        if (!cnt_last) begin
          cnt_d = cnt - CNT_W'(1);
        end else if (pre_n != '0) begin
          st_d  = PH_PRE;
          cnt_d = pre_n - CNT_W'(1);
        end else begin
          st_d  = PH_STRB;
          cnt_d = strb_n - CNT_W'(1);
        end
      end
      PH_PRE: begin
        if (!cnt_last) begin
          cnt_d = cnt - CNT_W'(1);
        end else begin
          st_d  = PH_STRB;
          cnt_d = strb_n - CNT_W'(1);
        end
      end
      PH_STRB: begin
        if (!cnt_last) begin
          cnt_d = cnt - CNT_W'(1);
        end else if (c_wr) begin
          st_d  = PH_HOLD;
          cnt_d = hold_n - CNT_W'(1);
        end else begin
          st_d  = PH_IDLE;
        end
      end
      PH_HOLD: begin
        if (!cnt_last) cnt_d = cnt - CNT_W'(1);
        else           st_d  = PH_IDLE;
      end
      default: begin
        st_d  = PH_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  // Next-cycle pin values, decoded from the next phase
  logic              act_d, oe_n_d, we_n_d, adv_n_d, doe_d;
  logic [NUM_CS-1:0] cs_n_d;

  assign act_d   = (st_d == PH_PRE) || (st_d == PH_STRB) || (st_d == PH_HOLD);
  assign oe_n_d  = !((st_d == PH_STRB) && !src_wr);
  assign we_n_d  = !((st_d == PH_STRB) && src_wr);
  assign adv_n_d = !((st_d == PH_PRE) && (st != PH_PRE));
  assign doe_d   = src_wr && ((st_d == PH_STRB) || (st_d == PH_HOLD));

  genvar g;
  generate
    for (g = 0; g < NUM_CS; g++) begin : g_csn
      assign cs_n_d[g] = !(act_d && (src_cs == CSW'(g)));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= PH_IDLE;
      cnt       <= '0;
      c_wr      <= 1'b0;
      c_first   <= 1'b0;
      c_cs      <= '0;
      c_cfg     <= '0;
      ext_addr  <= '0;
      ext_dout  <= '0;
      ext_doe   <= 1'b0;
      ext_cs_n  <= '1;
      ext_oe_n  <= 1'b1;
      ext_we_n  <= 1'b1;
      ext_adv_n <= 1'b1;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      st        <= st_d;
      cnt       <= cnt_d;
      ext_doe   <= doe_d;
      ext_cs_n  <= cs_n_d;
      ext_oe_n  <= oe_n_d;
      ext_we_n  <= we_n_d;
      ext_adv_n <= adv_n_d;
      if (start) begin
        c_wr     <= wr;
        c_first  <= first;
        c_cs     <= cs;
        c_cfg    <= tcfg;
        ext_addr <= addr;
        ext_dout <= wdata;
      end
      rsp_valid <= 1'b0;
      if (st == PH_STRB && cnt_last && !c_wr) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= ext_din;
      end else if (st == PH_NULL && !c_wr) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= '0;
      end
    end
  end

endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbc_pkg::*;
#(
  parameter int NUM_CS = 6,
  parameter int AW     = 9,
  parameter int DW     = 16,
  localparam int CSW   = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CSW-1:0]    cfg_cs,
  input  logic [CFG_W-1:0]  cfg_word,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_wr,
  input  logic [CSW-1:0]    req_cs,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  output logic [AW-1:0]     ext_addr,
  output logic [DW-1:0]     ext_dout,
  output logic              ext_doe,
  input  logic [DW-1:0]     ext_din,
  output logic [NUM_CS-1:0] ext_cs_n,
  output logic              ext_oe_n,
  output logic              ext_we_n,
  output logic              ext_adv_n
);

  tcfg_t  sel_cfg;
  logic   accept;
  logic   cs_ok;
  logic   need_rec;
  logic   first_acc;
  logic   seq_idle;
  phase_t seq_phase;

  assign cs_ok     = (int'(req_cs) < NUM_CS);
  assign accept    = req_valid && seq_idle;
  assign req_ready = seq_idle;

  xbc_cfg_bank #(.NUM_CS(NUM_CS), .CSW(CSW)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr),
    .wr_sel  (cfg_cs),
    .wr_word (tcfg_t'(cfg_word)),
    .rd_sel  (req_cs),
    .rd_word (sel_cfg)
  );

  xbc_turn #(.CSW(CSW)) u_turn (
    .clk      (clk),
    .rst_n    (rst_n),
    .log_en   (accept && cs_ok),
    .cs       (req_cs),
    .wr       (req_wr),
    .need_rec (need_rec),
    .first    (first_acc)
  );

  xbc_seq #(.NUM_CS(NUM_CS), .CSW(CSW), .AW(AW), .DW(DW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .cs_ok     (cs_ok),
    .wr        (req_wr),
    .cs        (req_cs),
    .addr      (req_addr),
    .wdata     (req_wdata),
    .tcfg      (sel_cfg),
    .need_rec  (need_rec),
    .first     (first_acc),
    .ext_din   (ext_din),
    .idle      (seq_idle),
    .phase     (seq_phase),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .ext_addr  (ext_addr),
    .ext_dout  (ext_dout),
    .ext_doe   (ext_doe),
    .ext_cs_n  (ext_cs_n),
    .ext_oe_n  (ext_oe_n),
    .ext_we_n  (ext_we_n),
    .ext_adv_n (ext_adv_n)
  );

endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk
  import xbc_pkg::*;
#(
  parameter int NUM_CS = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [NUM_CS-1:0] ext_cs_n,
  input logic              ext_oe_n,
  input logic              ext_we_n,
  input logic              ext_adv_n,
  input logic              ext_doe,
  input phase_t            phase
);

  // R3: never two chip selects at once
  p_cs_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ext_cs_n));

  // R3: a strobe only under an asserted chip select
  p_strobe_in_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_oe_n || !ext_we_n) |-> ($countones(~ext_cs_n) == 1));

  // R10: output enable and write enable never together
  p_oe_we_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ext_oe_n && !ext_we_n));

  // R10: no drive while the memory may drive
  p_no_drive_on_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ext_doe |-> ext_oe_n);

  // R7: recovery cycles keep the bus quiet
  p_rec_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_REC) |-> (&ext_cs_n && !ext_doe && ext_oe_n));

  // R11: busy on the cycle after acceptance
  p_busy_after_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R8: response pulse only once the access has finished
  p_rsp_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (req_ready && ext_oe_n));

  // R9: address valid lasts a single cycle
  p_adv_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_adv_n |=> ext_adv_n);

endmodule

bind xbus_ctrl xbus_ctrl_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .ext_cs_n  (ext_cs_n),
  .ext_oe_n  (ext_oe_n),
  .ext_we_n  (ext_we_n),
  .ext_adv_n (ext_adv_n),
  .ext_doe   (ext_doe),
  .phase     (seq_phase)
);

// File: tb/xbus_ctrl_bench.sv
module xbus_ctrl_bench;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_cs = '0;
  logic [39:0] cfg_word = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_wr = 1'b0;
  logic [2:0]  req_cs = '0;
  logic [8:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [8:0]  ext_addr;
  logic [15:0] ext_dout;
  logic        ext_doe;
  logic [15:0] ext_din = '0;
  logic [5:0]  ext_cs_n;
  logic        ext_oe_n, ext_we_n, ext_adv_n;

  always #(CLK_P/2) clk = ~clk;

  xbus_ctrl u_xbus_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_cs(cfg_cs), .cfg_word(cfg_word),
    .req_valid(req_valid), .req_ready(req_ready), .req_wr(req_wr), .req_cs(req_cs),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .ext_addr(ext_addr), .ext_dout(ext_dout), .ext_doe(ext_doe), .ext_din(ext_din),
    .ext_cs_n(ext_cs_n), .ext_oe_n(ext_oe_n), .ext_we_n(ext_we_n), .ext_adv_n(ext_adv_n)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // bench model state
  logic [39:0] mcfg [6];
  bit          h_vld = 1'b0;
  bit          h_rd = 1'b0;
  int          h_cs = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [39:0] mk(int alt, int ah, int a2o, int rh, int wd, int rd,
                                     int rc, int wh, int ww, int rw);
    return {alt[0], ah[0], a2o[1:0], rh[3:0], wd[7:0], rd[7:0], rc[3:0], wh[3:0], ww[3:0], rw[3:0]};
  endfunction

  // expected phase lengths, restated from the requirements
  function automatic int e_strobe(logic [39:0] w, bit wr, bit first);
    int n;
    n = wr ? int'(w[7:4]) + 1 : int'(w[3:0]) + 1;
    if (first) n += wr ? int'(w[31:24]) : int'(w[23:16]);
    return n;
  endfunction

  function automatic int e_setup(logic [39:0] w, bit wr);
    if (!w[39]) return 0;
    return wr ? 1 + int'(w[38]) : 1 + int'(w[38]) + int'(w[37:36]) + int'(w[35:32]);
  endfunction

  function automatic int e_recov(logic [39:0] w);
    return (w[15:12] == 4'd0) ? 1 : int'(w[15:12]);
  endfunction

  function automatic logic [15:0] mem_word(logic [8:0] a, int cs);
    return 16'h5A00 ^ {7'd0, a} ^ (16'(cs) << 12);
  endfunction

  task automatic set_cfg(input int cs, input logic [39:0] w);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_cs = 3'(cs); cfg_word = w;
    @(negedge clk);
    cfg_wr = 1'b0;
    if (cs < 6) mcfg[cs] = w;
  endtask

  task automatic access(input bit wr, input int cs, input logic [8:0] a, input logic [15:0] d);
    bit ok_cs, first, rec;
    int x_rec, x_pre, x_strb, x_hold, x_adv;
    int g_rec, g_pre, g_strb, g_hold, g_adv, tot;
    int cs_err, drv_err, rsp_err;
    logic [15:0] rv;
    ok_cs = (cs < 6);
    g_rec = 0; g_pre = 0; g_strb = 0; g_hold = 0; g_adv = 0; tot = 0;
    cs_err = 0; drv_err = 0; rsp_err = 0;
    if (ok_cs) begin
      first  = !h_vld || (h_cs != cs);
      rec    = h_vld && h_rd && ((h_cs != cs) || wr);
      x_rec  = rec ? e_recov(mcfg[cs]) : 0;
      x_pre  = e_setup(mcfg[cs], wr);
      x_strb = e_strobe(mcfg[cs], wr, first);
      x_hold = wr ? int'(mcfg[cs][11:8]) + 1 : 0;
      x_adv  = mcfg[cs][39] ? 1 : 0;
      rv     = mem_word(a, cs);
    end else begin
      first = 1'b0; rec = 1'b0;
      x_rec = 1; x_pre = 0; x_strb = 0; x_hold = 0; x_adv = 0;
      rv = 16'h0000;
    end
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_wr = wr; req_cs = 3'(cs); req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready && tot < 4000) begin
      tot++;
      if (rsp_valid) rsp_err++;
      if (&ext_cs_n) begin
        if (g_pre + g_strb + g_hold != 0) cs_err++;
        if (ext_doe) drv_err++;
        g_rec++;
      end else begin
        if (ext_cs_n != ~(6'd1 << cs)) cs_err++;
        if (!ext_adv_n) g_adv++;
        if (!ext_oe_n || !ext_we_n) begin
          if (!ext_oe_n) begin
            ext_din = (g_strb == x_strb - 1) ? rv : ~rv;
            if (ext_doe || wr) drv_err++;
          end else begin
            if (!ext_doe || ext_dout != d || !wr) drv_err++;
          end
          g_strb++;
        end else if (g_strb == 0) begin
          if (ext_doe) drv_err++;
          g_pre++;
        end else begin
          if (!ext_doe || ext_dout != d) drv_err++;
          g_hold++;
        end
      end
      @(negedge clk);
    end
    chk(g_rec == x_rec, "R7 recovery cycles", g_rec, x_rec);
    chk(g_pre == x_pre, "R9 setup cycles", g_pre, x_pre);
    chk(g_adv == x_adv, "R9 address valid cycles", g_adv, x_adv);
    chk(g_strb == x_strb, "R4 R5 strobe cycles", g_strb, x_strb);
    chk(g_hold == x_hold, "R6 write hold cycles", g_hold, x_hold);
    chk(tot == x_rec + x_pre + x_strb + x_hold, "R11 busy cycles", tot, x_rec + x_pre + x_strb + x_hold);
    chk(cs_err == 0, "R3 chip select pattern errors", cs_err, 0);
    chk(drv_err == 0, "R10 data drive errors", drv_err, 0);
    chk(rsp_err == 0, "R8 early response pulses", rsp_err, 0);
    chk(rsp_valid == !wr, "R8 response pulse", int'(rsp_valid), int'(!wr));
    if (!wr) chk(rsp_rdata == rv, ok_cs ? "R8 read data" : "R12 null read data", int'(rsp_rdata), int'(rv));
    if (ok_cs) begin
      h_vld = 1'b1; h_rd = !wr; h_cs = cs;
    end
  endtask

  initial begin
    for (int i = 0; i < 6; i++) mcfg[i] = '0;
    void'($urandom(32'd2024));
    #(CLK_P*3);
    @(negedge clk);
    chk(ext_cs_n == 6'h3F && ext_oe_n && ext_we_n && ext_adv_n, "R1 strobes in reset", int'(ext_cs_n), 63);
    chk(!ext_doe, "R1 bus released in reset", int'(ext_doe), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid, "R1 ready after reset", int'(req_ready), 1);
    chk(ext_cs_n == 6'h3F && ext_oe_n && ext_we_n && ext_adv_n, "R1 strobes after reset", int'(ext_cs_n), 63);

    // all-zero words: wait=1, hold=1, recovery rounds up to 1
    access(1'b0, 0, 9'h011, 16'h0);        // first, no recovery
    access(1'b0, 0, 9'h012, 16'h0);        // read-read same cs: no recovery
    access(1'b1, 0, 9'h013, 16'hBEEF);     // read-write same cs: recovery 1

    set_cfg(0, mk(0, 0, 0, 0, 5, 3, 0, 2, 1, 2));
    set_cfg(1, mk(0, 0, 0, 0, 0, 0, 3, 0, 0, 4));
    set_cfg(2, mk(1, 1, 2, 1, 0, 0, 2, 1, 3, 2));
    set_cfg(3, mk(0, 0, 0, 0, 255, 255, 15, 15, 15, 15));
    set_cfg(4, mk(1, 0, 3, 15, 7, 9, 4, 0, 0, 0));
    set_cfg(5, mk(1, 0, 0, 0, 0, 0, 0, 0, 0, 0));

    access(1'b1, 0, 9'h020, 16'h1234);     // write-write, same cs, not first (R5)
    access(1'b1, 1, 9'h021, 16'h2222);     // first on cs1 (R5)
    access(1'b0, 1, 9'h022, 16'h0);        // write then read: no recovery
    access(1'b0, 2, 9'h023, 16'h0);        // read then other cs: recovery 2, alt read
    access(1'b1, 2, 9'h024, 16'h3333);     // read then write same cs, alt write
    access(1'b0, 3, 9'h1FF, 16'h0);        // max latency first read
    access(1'b0, 6, 9'h000, 16'h0);        // R12 null read
    access(1'b1, 7, 9'h000, 16'h7777);     // R12 null write
    access(1'b1, 3, 9'h100, 16'h4444);     // history still cs3 read: recovery 15
    access(1'b0, 4, 9'h0AA, 16'h0);        // alt read with full gaps
    access(1'b0, 5, 9'h0AB, 16'h0);        // alt minimum setup

    // R2: write to slot 6 must not disturb any real slot
    set_cfg(6, '1);
    set_cfg(7, '1);
    access(1'b0, 0, 9'h030, 16'h0);
    access(1'b1, 1, 9'h031, 16'h5555);

    for (int k = 0; k < 160; k++) begin
      if ($urandom_range(0, 9) == 0) begin
        int c;
        logic [39:0] w;
        c = $urandom_range(0, 7);
        w = {$urandom(), $urandom()} & 40'hFF_3F3F_FFFF;  // keep latencies moderate
        set_cfg(c, w);
      end
      access(1'($urandom_range(0, 1)), $urandom_range(0, 7), 9'($urandom()), 16'($urandom()));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule